// File: doc/BRIEF.md
# Serially Loaded Window Page Mapper

This block translates a 16-bit CPU address into a 19-bit physical address for a 512K memory arranged as 32 pages of 16K. The CPU address space is cut into four 16K windows. CPU address bits 15:14 pick a window, and each window carries its own 5-bit page number. That page number becomes physical bits 18:14. CPU bits 13:0 pass straight through as the offset inside the page. The translation path is purely combinational, so it follows CPU address changes without waiting for a clock.

The four page numbers, 20 bits in all, arrive from an external controller over a three-wire serial link: a serial clock, an active-low select and a data line. The serial inputs are brought into the system clock domain and shifted into a staging chain. Raising the select copies the whole chain into the active map in a single clock edge, so a new map takes effect as one complete set. A busy output covers the whole serial transaction, and a CPU-side controller can use it to hold the processor off while the map changes.

Top module: `win_page_mapper`

## Requirements
- R1: Physical bits 18:14 equal the page number of the window selected by CPU bits 15:14. Window w takes its page from bits [5w+4:5w] of the 20-bit serial word.
- R2: Physical bits 13:0 always equal CPU bits 13:0.
- R3: While select is low, each rising serial clock edge shifts in one data bit. The 20-bit word is sent most significant bit first, so the window 3 field goes first and the window 0 field goes last.
- R4: The active map changes only when select rises. While bits are still being shifted, translation keeps using the previous map.
- R5: If more than 20 bits are shifted in one transaction, only the last 20 bits take effect.
- R6: Serial clock edges while select is high do not change the staging chain. A later transaction with no clock edges then latches the previously loaded map unchanged.
- R7: After reset, every window maps to page 0 and busy is low.
- R8: Busy goes high within five system clock cycles after select falls. It stays high until the map update and goes low in the same cycle that the new map takes effect.
- R9: The translation responds to a CPU address change with no system clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the map controller |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_sdi | input | 1 | Serial map data |
| cpu_addr | input | 16 | CPU address |
| phys_addr | output | 19 | Translated physical address |
| map_busy | output | 1 | High while a map transaction is in progress |

## Verification
The bench uses the default parameters: two window-select bits, five page bits, a 14-bit offset and two synchronizer stages. This gives exactly the four windows and 32 pages of the target memory. Every page value from 0 to 31 is reachable, including all-ones and single-bit patterns that show a swapped or misaligned field. With a two-stage synchronizer the busy latency and the serial-edge spacing stay short, so over-length transactions, clock edges while deselected, and probes in the middle of a transaction all fit in a short run.

// File: rtl/wpm_pkg.sv
`timescale 1ns/1ps
package wpm_pkg;
  localparam int DEF_WIN_BITS    = 2;
  localparam int DEF_PAGE_BITS   = 5;
  localparam int DEF_OFFS_BITS   = 14;
  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/wpm_sync.sv
`timescale 1ns/1ps
module wpm_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wpm_serial_loader.sv
`timescale 1ns/1ps
module wpm_serial_loader #(
  parameter int CHAIN_W     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               sdi,
  output logic [CHAIN_W-1:0] map_q,
  output logic               busy
);
  logic [2:0]         s;
  logic               sclk_d, cs_d;
  logic [CHAIN_W-1:0] chain;
  logic               shift_en, cs_rise, cs_fall;

  // order {sclk, cs_n, sdi}; select idles high
  wpm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk, cs_n, sdi}),
    .q   (s)
  );

  assign shift_en = s[2] & ~sclk_d & ~s[1];
  assign cs_rise  = s[1] & ~cs_d;
  assign cs_fall  = ~s[1] & cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      chain  <= '0;
      map_q  <= '0;
      busy   <= 1'b0;
    end else begin
      sclk_d <= s[2];
      cs_d   <= s[1];
      if (shift_en) chain <= {chain[CHAIN_W-2:0], s[0]};
      if (cs_rise) begin
        map_q <= chain;
        busy  <= 1'b0;
      end else if (cs_fall) begin
        busy  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wpm_addr_select.sv
`timescale 1ns/1ps
module wpm_addr_select #(
  parameter int WIN_BITS  = 2,
  parameter int PAGE_BITS = 5,
  parameter int OFFS_BITS = 14
) (
  input  logic [(1<<WIN_BITS)*PAGE_BITS-1:0] map_q,
  input  logic [OFFS_BITS+WIN_BITS-1:0]      cpu_addr,
  output logic [OFFS_BITS+PAGE_BITS-1:0]     phys_addr
);
  localparam int NUM_WIN = 1 << WIN_BITS;

  logic [PAGE_BITS-1:0] win_pg [NUM_WIN];
  logic [WIN_BITS-1:0]  sel;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_pg[w] = map_q[w*PAGE_BITS +: PAGE_BITS];
  end

  assign sel = cpu_addr[OFFS_BITS +: WIN_BITS];

  always_comb begin
    phys_addr = {win_pg[sel], cpu_addr[OFFS_BITS-1:0]};
  end
endmodule

// File: rtl/win_page_mapper.sv
`timescale 1ns/1ps
module win_page_mapper
  import wpm_pkg::*;
#(
  parameter int WIN_BITS    = DEF_WIN_BITS,
  parameter int PAGE_BITS   = DEF_PAGE_BITS,
  parameter int OFFS_BITS   = DEF_OFFS_BITS,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           spi_sclk,
  input  logic                           spi_cs_n,
  input  logic                           spi_sdi,
  input  logic [OFFS_BITS+WIN_BITS-1:0]  cpu_addr,
  output logic [OFFS_BITS+PAGE_BITS-1:0] phys_addr,
  output logic                           map_busy
);
  localparam int NUM_WIN = 1 << WIN_BITS;
  localparam int CHAIN_W = NUM_WIN * PAGE_BITS;

  logic [CHAIN_W-1:0] map_q;

  wpm_serial_loader #(.CHAIN_W(CHAIN_W), .SYNC_STAGES(SYNC_STAGES)) u_load (
    .clk   (clk),
    .rst   (rst),
    .sclk  (spi_sclk),
    .cs_n  (spi_cs_n),
    .sdi   (spi_sdi),
    .map_q (map_q),
    .busy  (map_busy)
  );

  wpm_addr_select #(.WIN_BITS(WIN_BITS), .PAGE_BITS(PAGE_BITS), .OFFS_BITS(OFFS_BITS)) u_sel (
    .map_q     (map_q),
    .cpu_addr  (cpu_addr),
    .phys_addr (phys_addr)
  );
endmodule

// File: rtl/wpm_checker.sv
`timescale 1ns/1ps
module wpm_checker #(
  parameter int WIN_BITS  = 2,
  parameter int PAGE_BITS = 5,
  parameter int OFFS_BITS = 14
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic [OFFS_BITS+WIN_BITS-1:0]        cpu_addr,
  input logic [OFFS_BITS+PAGE_BITS-1:0]       phys_addr,
  input logic                                 map_busy,
  input logic [(1<<WIN_BITS)*PAGE_BITS-1:0]   map_q
);
  logic [PAGE_BITS-1:0] exp_pg;
  always_comb begin
    exp_pg = '0;
    for (int w = 0; w < (1 << WIN_BITS); w++)
      if (cpu_addr[OFFS_BITS +: WIN_BITS] == WIN_BITS'(w))
        exp_pg = map_q[w*PAGE_BITS +: PAGE_BITS];
  end

  a_r1_page_select: assert property (@(posedge clk) disable iff (rst)
    phys_addr[OFFS_BITS +: PAGE_BITS] == exp_pg);

  a_r2_offset_pass: assert property (@(posedge clk) disable iff (rst)
    phys_addr[OFFS_BITS-1:0] == cpu_addr[OFFS_BITS-1:0]);

  a_r4_map_holds_while_busy: assert property (@(posedge clk) disable iff (rst)
    map_busy |=> ($stable(map_q) || !map_busy));

  a_r8_busy_low_on_update: assert property (@(posedge clk) disable iff (rst)
    !$stable(map_q) |-> !map_busy);

  a_r8_busy_rise_keeps_map: assert property (@(posedge clk) disable iff (rst)
    $rose(map_busy) |-> $stable(map_q));
endmodule

bind win_page_mapper wpm_checker #(
  .WIN_BITS(WIN_BITS), .PAGE_BITS(PAGE_BITS), .OFFS_BITS(OFFS_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .phys_addr (phys_addr),
  .map_busy  (map_busy),
  .map_q     (map_q)
);

// File: tb/sim_win_page_mapper.sv
`timescale 1ns/1ps
module sim_win_page_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [18:0] phys_addr;
  logic        busy;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  win_page_mapper u0 (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .cpu_addr(cpu_addr), .phys_addr(phys_addr), .map_busy(busy)
  );

  // maps as {w3, w2, w1, w0}
  localparam logic [19:0] MAPS [4] = '{
    {5'd31, 5'd0,  5'd21, 5'd10},
    {5'd1,  5'd2,  5'd3,  5'd4},
    {5'd16, 5'd8,  5'd4,  5'd2},
    {5'd7,  5'd7,  5'd7,  5'd7}
  };
  localparam logic [13:0] OFFS [4] = '{14'h0000, 14'h3FFF, 14'h1555, 14'h2AAA};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      clks(4);
      sclk = 1'b1;
      clks(4);
      sclk = 1'b0;
    end
  endtask

  task automatic load(input logic [31:0] bits, input int n);
    cs_n = 1'b0;
    clks(4);
    shift_bits(bits, n);
    clks(4);
    cs_n = 1'b1;
    clks(8);
  endtask

  function automatic logic [18:0] xlate(input logic [19:0] m, input logic [15:0] a);
    return {m[a[15:14]*5 +: 5], a[13:0]};
  endfunction

  task automatic probe(input string req, input logic [19:0] m, input logic [15:0] a);
    cpu_addr = a;
    #1;
    chk(req, 32'(phys_addr), 32'(xlate(m, a)));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clks(3);
    rst = 1'b0;
    clks(2);
    // R7: reset state
    chk("R7 busy", 32'(busy), 0);
    probe("R7 page0", 20'h0, 16'hC123);
    probe("R7 page0", 20'h0, 16'h7FFF);

    // table: R1 R2 R3
    for (int t = 0; t < 4; t++) begin
      load(32'(MAPS[t]), 20);
      chk("R8 busy idle", 32'(busy), 0);
      for (int w = 0; w < 4; w++)
        probe("R1/R2/R3 map", MAPS[t], {w[1:0], OFFS[w]});
    end

    // R9: address change, no clock edge
    @(posedge clk); #2;
    cpu_addr = 16'h4001; #1;
    chk("R9 comb", 32'(phys_addr), 32'(xlate(MAPS[3], 16'h4001)));
    cpu_addr = 16'hBFFE; #1;
    chk("R9 comb", 32'(phys_addr), 32'(xlate(MAPS[3], 16'hBFFE)));

    // R4 and R8: mid-transaction
    load(32'(MAPS[0]), 20);
    cs_n = 1'b0;
    clks(6);
    chk("R8 busy rise", 32'(busy), 1);
    shift_bits(32'(MAPS[1][19:10]), 10);
    probe("R4 old map", MAPS[0], 16'hC000);
    probe("R4 old map", MAPS[0], 16'h4000);
    chk("R8 busy held", 32'(busy), 1);
    shift_bits(32'(MAPS[1][9:0]), 10);
    clks(4);
    probe("R4 before rise", MAPS[0], 16'h0000);
    cs_n = 1'b1;
    clks(8);
    chk("R8 busy fall", 32'(busy), 0);
    probe("R4 new map", MAPS[1], 16'hC000);
    probe("R4 new map", MAPS[1], 16'h0000);

    // R5: 25 bits, last 20 kept
    load({7'd0, 5'b10101, MAPS[2]}, 25);
    for (int w = 0; w < 4; w++)
      probe("R5 overlong", MAPS[2], {w[1:0], 14'h0ABC});

    // R6: clock edges while deselected ignored
    sdi = 1'b1;
    for (int i = 0; i < 6; i++) begin
      clks(4); sclk = 1'b1; clks(4); sclk = 1'b0;
    end
    load(32'h0, 0);
    for (int w = 0; w < 4; w++)
      probe("R6 ignored", MAPS[2], {w[1:0], 14'h0123});

    // R7: reset returns map to page 0
    rst = 1'b1;
    clks(2);
    rst = 1'b0;
    clks(2);
    chk("R7 busy after reset", 32'(busy), 0);
    probe("R7 page0 again", 20'h0, 16'hFFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule